// File: doc/BRIEF.md
# Bit-serial shift-add multiplier

This block forms the unsigned product of two W-bit operands with a single full adder and one carry flip-flop in place of a parallel adder. Four W-bit right-shift registers hold the multiplicand (which rotates), the multiplier, and the upper and lower halves of the 2W-bit product. A pulse on `start` while the block is idle loads both operands in parallel and clears the product halves and the carry.

A controller then runs a nested loop with one outer pass per multiplier bit. Each pass spends W cycles adding the multiplicand, gated by the current multiplier bit, into the upper half one bit at a time through the full adder. It closes with one cycle that moves the saved carry into the top of the upper half, moves one finished bit from the upper half into the lower half, clears the carry and advances the multiplier. After W passes (W*(W+1) cycles) the product is complete and `done` pulses.

Top module: `bitser_mul`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to idle; after that edge `done` is 0 and `product` reads 0.
- R2: A clock edge with `start` high while the block is idle loads `mcand` and `mplier` and clears the product halves, so `product` reads 0 after that edge.
- R3: When `done` is 1, `product` equals the unsigned product `mcand * mplier` of the loaded operands, with bits [2W-1:W] as the upper half and bits [W-1:0] as the lower half (for W=4, 4'b1011 times 4'b0101 gives 8'b00110111).
- R4: `done` becomes 1 after exactly W*(W+1) clock edges following the edge that loaded the operands, that is, it is first seen high after the (W*(W+1)+1)-th edge counted from and including the load edge.
- R5: `done` is high for exactly one clock cycle per multiply.
- R6: `start` and any change of `mcand` or `mplier` while a multiply is running have no effect on the result or its timing.
- R7: While idle with `start` low, `product` holds its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Load operands and begin a multiply when idle |
| mcand | input | W | Multiplicand, sampled on the load edge |
| mplier | input | W | Multiplier, sampled on the load edge |
| done | output | 1 | One-cycle pulse when the product is complete |
| product | output | 2W | Upper half and lower half of the product |

## Verification
The assertions take for granted that `rst` is held high for at least one edge before the first `start`, and that operand values only matter on the load edge, so the captured multiplicand copy in the checker reflects what the datapath loaded. The stimulus asserts reset first, presents operands together with a one-cycle `start` on the falling edge, and deliberately raises `start` with garbage operands in the middle of a run to probe that busy-time requests are dropped. Random operands come from a fixed-seed generator, with zero and all-ones operands added as directed cases at both widths.

// File: rtl/bsm_pkg.sv
package bsm_pkg;

  typedef struct packed {
    logic sh_mcand;
    logic sh_mplier;
    logic sh_upper;
    logic sh_lower;
    logic sel_sum;
    logic clr_carry;
  } bsm_ctl_t;

  function automatic logic fa_sum(input logic x, input logic y, input logic ci);
    return x ^ y ^ ci;
  endfunction

  function automatic logic fa_cout(input logic x, input logic y, input logic ci);
    return (x & y) | (x & ci) | (y & ci);
  endfunction

endpackage

// File: rtl/bsm_shreg.sv
module bsm_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] ld_val,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (load)  q <= ld_val;
    else if (shift) q <= {sin, q[W-1:1]};
  end

endmodule

// File: rtl/bsm_ctrl.sv
module bsm_ctrl
  import bsm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     start,
  output logic     load,
  output logic     busy,
  output logic     inner_cyc,
  output logic     close_cyc,
  output logic     done,
  output bsm_ctl_t ctl
);

  localparam int JW = $clog2(W + 1);
  localparam int IW = (W > 1) ? $clog2(W) : 1;
  localparam logic [JW-1:0] J_CLOSE = JW'(W);
  localparam logic [IW-1:0] I_LAST  = IW'(W - 1);

  logic          busy_q;
  logic [JW-1:0] j_q;
  logic [IW-1:0] i_q;
  logic          last_close;

  assign busy       = busy_q;
  assign load       = start && !busy_q;
  assign inner_cyc  = busy_q && (j_q != J_CLOSE);
  assign close_cyc  = busy_q && (j_q == J_CLOSE);
  assign last_close = close_cyc && (i_q == I_LAST);

  always_comb begin
    ctl           = '0;
    ctl.sh_mcand  = inner_cyc;
    ctl.sel_sum   = inner_cyc;
    ctl.sh_upper  = inner_cyc || close_cyc;
    ctl.sh_mplier = close_cyc;
    ctl.sh_lower  = close_cyc;
    ctl.clr_carry = close_cyc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      j_q    <= '0;
      i_q    <= '0;
      done   <= 1'b0;
    end else begin
      done <= last_close;
      if (load) begin
        busy_q <= 1'b1;
        j_q    <= '0;
        i_q    <= '0;
      end else if (busy_q) begin
        if (close_cyc) begin
          j_q <= '0;
          i_q <= i_q + 1'b1;
          if (last_close) busy_q <= 1'b0;
        end else begin
          j_q <= j_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/bitser_mul.sv
module bitser_mul
  import bsm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic           done,
  output logic [2*W-1:0] product
);

  bsm_ctl_t     ctl;
  logic         load;
  logic         busy;
  logic         inner_cyc;
  logic         close_cyc;
  logic [W-1:0] a_q;
  logic [W-1:0] b_q;
  logic [W-1:0] hi_q;
  logic [W-1:0] lo_q;
  logic         cy_q;
  logic         pp_bit;
  logic         sum_bit;
  logic         cout_bit;
  logic         hi_in;

  bsm_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .load(load), .busy(busy),
    .inner_cyc(inner_cyc), .close_cyc(close_cyc), .done(done), .ctl(ctl)
  );

  assign pp_bit   = a_q[0] & b_q[0];
  assign sum_bit  = fa_sum(hi_q[0], pp_bit, cy_q);
  assign cout_bit = fa_cout(hi_q[0], pp_bit, cy_q);
  assign hi_in    = ctl.sel_sum ? sum_bit : cy_q;

  bsm_shreg #(.W(W)) u_mcand (
    .clk(clk), .rst(rst), .load(load), .ld_val(mcand),
    .shift(ctl.sh_mcand), .sin(a_q[0]), .q(a_q)
  );

  bsm_shreg #(.W(W)) u_mplier (
    .clk(clk), .rst(rst), .load(load), .ld_val(mplier),
    .shift(ctl.sh_mplier), .sin(1'b0), .q(b_q)
  );

  bsm_shreg #(.W(W)) u_upper (
    .clk(clk), .rst(rst), .load(load), .ld_val('0),
    .shift(ctl.sh_upper), .sin(hi_in), .q(hi_q)
  );

  bsm_shreg #(.W(W)) u_lower (
    .clk(clk), .rst(rst), .load(load), .ld_val('0),
    .shift(ctl.sh_lower), .sin(hi_q[0]), .q(lo_q)
  );

  always_ff @(posedge clk) begin
    if (rst)                        cy_q <= 1'b0;
    else if (load || ctl.clr_carry) cy_q <= 1'b0;
    else if (inner_cyc)             cy_q <= cout_bit;
  end

  assign product = {hi_q, lo_q};

endmodule

// File: rtl/bsm_chk.sv
module bsm_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic [W-1:0]   mcand,
  input logic           done,
  input logic [2*W-1:0] product,
  input logic           busy,
  input logic           inner_cyc,
  input logic           close_cyc,
  input logic [W-1:0]   a_q,
  input logic           carry_q
);

  logic [W-1:0] a_ref;

  always_ff @(posedge clk) begin
    if (rst)                a_ref <= '0;
    else if (start && !busy) a_ref <= mcand;
  end

  // R1: reset leaves the block idle and silent
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!done && !busy && product == '0));

  // R2: a load clears the product halves
  a_r2_load_clears: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (product == '0 && busy));

  // R3: multiplicand is back to its loaded value at each closing cycle
  a_r3_mcand_restored: assert property (@(posedge clk) disable iff (rst)
    close_cyc |-> (a_q == a_ref));

  // R3: carry is empty after each closing cycle
  a_r3_carry_cleared: assert property (@(posedge clk) disable iff (rst)
    close_cyc |=> !carry_q);

  // R4: while running exactly one phase is active
  a_r4_phase_onehot: assert property (@(posedge clk) disable iff (rst)
    busy |-> $onehot({inner_cyc, close_cyc}));

  // R4: done follows a closing cycle
  a_r4_done_after_close: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(close_cyc));

  // R5: done is a single-cycle pulse
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6: start while running does not restart or stop the run
  a_r6_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && start && inner_cyc) |=> busy);

  // R7: idle product is held
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(product));

endmodule

bind bitser_mul bsm_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .mcand(mcand), .done(done),
  .product(product), .busy(busy), .inner_cyc(inner_cyc),
  .close_cyc(close_cyc), .a_q(a_q), .carry_q(cy_q)
);

// File: tb/bitser_mul_tb_top.sv
module bitser_mul_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int N8 = 8 * 9;
  localparam int N4 = 4 * 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  mc8 = '0, mp8 = '0;
  logic [3:0]  mc4 = '0, mp4 = '0;
  logic        done8, done4;
  logic [15:0] prod8;
  logic [7:0]  prod4;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bitser_mul #(.W(8)) dut_i (
    .clk(clk), .rst(rst), .start(start), .mcand(mc8), .mplier(mp8),
    .done(done8), .product(prod8)
  );

  bitser_mul #(.W(4)) dut_n4_i (
    .clk(clk), .rst(rst), .start(start), .mcand(mc4), .mplier(mp4),
    .done(done4), .product(prod4)
  );

  // reference: sum of left-shifted copies selected by multiplier bits
  function automatic logic [31:0] ref_mul(input logic [15:0] a, input logic [15:0] b, input int w);
    logic [31:0] acc = '0;
    for (int k = 0; k < w; k++)
      if (b[k]) acc = acc + ({16'd0, a} << k);
    return acc;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
      end
    end
  end

  task automatic mul_both(input logic [7:0] a8, input logic [7:0] b8,
                          input logic [3:0] a4, input logic [3:0] b4,
                          input bit poke);
    logic [15:0] e8;
    logic [7:0]  e4;
    int t8 = 0, t4 = 0;
    e8 = ref_mul({8'd0, a8}, {8'd0, b8}, 8) & 32'hFFFF;
    e4 = 8'(ref_mul({12'd0, a4}, {12'd0, b4}, 4));
    @(negedge clk);
    mc8 = a8; mp8 = b8; mc4 = a4; mp4 = b4; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(prod8 == '0 && prod4 == '0, "R2 load clears product", {16'd0, prod8}, 32'd0);
    for (int k = 1; k <= N8 + 3; k++) begin
      if (poke && k == 6) begin
        start = 1'b1; mc8 = ~a8; mp8 = 8'h5A; mc4 = ~a4; mp4 = 4'h9;
      end else if (poke && k == 7) begin
        start = 1'b0;
      end
      if (done8) begin
        if (t8 == 0) begin
          t8 = k;
          check(prod8 == e8, poke ? "R6 R3 product w8" : "R3 product w8", {16'd0, prod8}, {16'd0, e8});
        end else begin
          check(1'b0, "R5 done8 pulse width", 32'd1, 32'd0);
        end
      end
      if (done4) begin
        if (t4 == 0) begin
          t4 = k;
          check(prod4 == e4, poke ? "R6 R3 product w4" : "R3 product w4", {24'd0, prod4}, {24'd0, e4});
        end else begin
          check(1'b0, "R5 done4 pulse width", 32'd1, 32'd0);
        end
      end
      if (t8 != 0 && k == t8 + 1) check(!done8, "R5 done8 low after pulse", {31'd0, done8}, 32'd0);
      if (t4 != 0 && k == t4 + 1) check(!done4, "R5 done4 low after pulse", {31'd0, done4}, 32'd0);
      @(negedge clk);
    end
    check(t8 == N8 + 1, "R4 latency w8", t8, N8 + 1);
    check(t4 == N4 + 1, "R4 latency w4", t4, N4 + 1);
    check(prod8 == e8, "R7 hold w8", {16'd0, prod8}, {16'd0, e8});
    check(prod4 == e4, "R7 hold w4", {24'd0, prod4}, {24'd0, e4});
  endtask

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!done8 && !done4, "R1 done low in reset", {30'd0, done8, done4}, 32'd0);
    check(prod8 == '0 && prod4 == '0, "R1 product zero in reset", {16'd0, prod8}, 32'd0);
    rst = 1'b0;

    mul_both(8'h00, 8'h00, 4'h0, 4'h0, 1'b0);
    mul_both(8'hFF, 8'hFF, 4'hF, 4'hF, 1'b0);
    mul_both(8'h00, 8'hFF, 4'h0, 4'hF, 1'b0);
    mul_both(8'hFF, 8'h00, 4'hF, 4'h0, 1'b0);
    mul_both(8'h01, 8'hFF, 4'b1011, 4'b0101, 1'b0);
    mul_both(8'hB7, 8'h6D, 4'hD, 4'h7, 1'b1);
    for (int n = 0; n < 40; n++)
      mul_both(8'($urandom), 8'($urandom), 4'($urandom), 4'($urandom), n % 5 == 0);

    // R1: reset in the middle of a run
    @(negedge clk);
    mc8 = 8'hC3; mp8 = 8'h3C; mc4 = 4'h3; mp4 = 4'hC; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(prod8 == '0 && !done8, "R1 mid-run reset w8", {16'd0, prod8}, 32'd0);
    check(prod4 == '0 && !done4, "R1 mid-run reset w4", {24'd0, prod4}, 32'd0);
    repeat (N8 + 5) begin
      @(negedge clk);
      if (done8 || done4) check(1'b0, "R1 no done after reset", {30'd0, done8, done4}, 32'd0);
    end
    finish_run();
  end

endmodule